// File: doc/BRIEF.md
# Triple-Parity Row Encoder

This block computes three independent check bytes for one stripe row of a storage array that must survive the loss of any three members. Data bytes from the member disks stream in one per cycle. The caller marks the first byte of a row and the last byte of a row. Over GF(2^8), the block builds three sums: a plain XOR sum (P), a sum with disk i weighted by {02}^i (Q), and a sum with disk i weighted by {04}^i (R).

Bytes must be presented from the highest disk index down to index 0. This order lets the weighted sums be built by Horner's rule: each valid cycle the running Q is scaled by {02}, the running R is scaled by {04}, and the new byte is added to each. The cycle after the final byte, the three results appear together with a one-cycle valid pulse. A new row may start on that same cycle. Idle cycles inside a row are allowed and leave the running sums untouched.

Top module: `tpr_row_encoder`

## Requirements
- R1: After reset, out_valid is 0 and out_p, out_q and out_r are all 8'h00.
- R2: On out_valid, out_p equals the XOR of every byte accepted in the row.
- R3: On out_valid, out_q equals the sum over the row of D_i·{02}^i in GF(2^8) with polynomial x^8+x^4+x^3+x^2+1 (reduction byte 8'h1D). D_i is the byte accepted i bytes before the end-of-row byte, so the end-of-row byte is D_0.
- R4: On out_valid, out_r equals the sum over the row of D_i·{04}^i in the same field, with the same indexing.
- R5: A byte accepted with in_eor=1 raises out_valid on the next cycle only. out_valid stays low in every other cycle.
- R6: A byte accepted with in_sor=1 discards all earlier state, so a row that starts on the cycle of the previous row's pulse gives the same result as an isolated row.
- R7: Cycles with in_valid=0 have no effect, whatever in_data, in_sor and in_eor carry.
- R8: A one-byte row (in_sor and in_eor both 1) gives P = Q = R = that byte.
- R9: Rows of up to 255 bytes are encoded correctly. In particular, a single 8'h01 at index 8 gives Q = 8'h1D, at index 12 gives Q = 8'hCD, and at index 254 gives Q = 8'h8E and R = 8'h47.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A data byte is presented this cycle |
| in_sor | input | 1 | The presented byte is the first of a row (highest index) |
| in_eor | input | 1 | The presented byte is the last of a row (index 0) |
| in_data | input | 8 | Data byte |
| out_valid | output | 1 | One-cycle pulse: row results are on out_p, out_q, out_r |
| out_p | output | 8 | XOR parity of the row |
| out_q | output | 8 | {02}-weighted parity of the row |
| out_r | output | 8 | {04}-weighted parity of the row |

## Verification
A wrong bit in a multiply network or a stale accumulator stays hidden until the row ends. It then shows as a wrong out_q or out_r value on the single cycle of the out_valid pulse. Because each byte is scaled once per later byte, an error in the byte at index i is multiplied by {02}^i or {04}^i before it reaches the port. Long rows with a lone nonzero byte at a known index therefore expose the exact power that is wrong. A start-of-row that fails to clear the running sums shows on the pulse of the second of two back-to-back rows. A gap cycle that is not ignored also corrupts the result of the row that contains it.

// File: rtl/tpr_gf_pkg.sv
package tpr_gf_pkg;
  localparam int unsigned SYM_W     = 8;
  localparam int unsigned MAX_DISKS = 255;
  localparam int unsigned CNT_W     = $clog2(MAX_DISKS + 1);
  localparam int unsigned NUM_LANES = 3;

  typedef logic [SYM_W-1:0] sym_t;

  // one multiply by {02}, reduction x^8 -> 8'h1D
  function automatic sym_t gf_x1(input sym_t a);
    sym_t b;
    b[7] = a[6];
    b[6] = a[5];
    b[5] = a[4];
    b[4] = a[7] ^ a[3];
    b[3] = a[7] ^ a[2];
    b[2] = a[7] ^ a[1];
    b[1] = a[0];
    b[0] = a[7];
    return b;
  endfunction

  // one multiply by {04}, both shift steps folded into one XOR level
  function automatic sym_t gf_x2(input sym_t a);
    sym_t b;
    b[7] = a[5];
    b[6] = a[4];
    b[5] = a[7] ^ a[3];
    b[4] = a[7] ^ a[2] ^ a[6];
    b[3] = a[7] ^ a[1] ^ a[6];
    b[2] = a[0] ^ a[6];
    b[1] = a[7];
    b[0] = a[6];
    return b;
  endfunction
endpackage

// File: rtl/gf_xstep.sv
module gf_xstep
  import tpr_gf_pkg::*;
#(
  parameter int unsigned STEP = 1
) (
  input  sym_t a_i,
  output sym_t y_o
);
  generate
    if (STEP == 0) begin : g_ident
      assign y_o = a_i;
    end else if (STEP == 1) begin : g_by2
      assign y_o = gf_x1(a_i);
    end else begin : g_by4
      assign y_o = gf_x2(a_i);
    end
  endgenerate
endmodule

// File: rtl/parity_lane.sv
module parity_lane
  import tpr_gf_pkg::*;
#(
  parameter int unsigned STEP = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  input  sym_t din,
  output sym_t acc_o
);
  sym_t acc_q;
  sym_t acc_d;
  sym_t scaled;

  gf_xstep #(.STEP(STEP)) u_step (
    .a_i (acc_q),
    .y_o (scaled)
  );

  always_comb begin
    acc_d = acc_q;
    if (en) begin
      acc_d = (clr ? '0 : scaled) ^ din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (en) begin
      acc_q <= acc_d;
    end
  end

  assign acc_o = acc_q;

  // R7: an idle cycle leaves the running sum untouched
  a_r7_idle_holds : assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc_q));

  // R6: a start byte discards earlier state, whatever it was
  a_r6_start_clears : assert property (@(posedge clk) disable iff (!rst_n)
    (en && clr) |=> (acc_q == $past(din)));
endmodule

// File: rtl/tpr_row_encoder.sv
module tpr_row_encoder
  import tpr_gf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sor,
  input  logic             in_eor,
  input  logic [SYM_W-1:0] in_data,
  output logic             out_valid,
  output logic [SYM_W-1:0] out_p,
  output logic [SYM_W-1:0] out_q,
  output logic [SYM_W-1:0] out_r
);
  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_ni = rst_pipe_q[1];

  sym_t lane_acc [NUM_LANES];

  // lane g scales its sum by {02}^g per byte: P, Q, R
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    parity_lane #(.STEP(g)) u_lane (
      .clk   (clk),
      .rst_n (rst_ni),
      .en    (in_valid),
      .clr   (in_sor),
      .din   (in_data),
      .acc_o (lane_acc[g])
    );
  end

  logic vld_q, vld_d;
  always_comb vld_d = in_valid & in_eor;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  // row length tracker for the 255-disk limit check
  logic [CNT_W-1:0] row_cnt_q, row_cnt_d;
  always_comb begin
    row_cnt_d = row_cnt_q;
    if (in_valid) begin
      if (in_sor) begin
        row_cnt_d = CNT_W'(1);
      end else if (row_cnt_q != CNT_W'(MAX_DISKS)) begin
        row_cnt_d = row_cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      row_cnt_q <= '0;
    end else if (in_valid) begin
      row_cnt_q <= row_cnt_d;
    end
  end

  assign out_valid = vld_q;
  assign out_p     = lane_acc[0];
  assign out_q     = lane_acc[1];
  assign out_r     = lane_acc[2];

  // R5: an end-of-row byte is always followed by the result pulse
  a_r5_pulse_after_eor : assert property (@(posedge clk) disable iff (!rst_ni)
    (in_valid && in_eor) |=> out_valid);

  // R8: a one-byte row reports the byte itself on all three parities
  a_r8_single_byte : assert property (@(posedge clk) disable iff (!rst_ni)
    (in_valid && in_sor && in_eor) |=>
      (out_p == $past(in_data) && out_q == $past(in_data) && out_r == $past(in_data)));

  // R9: a row never grows beyond 255 data bytes
  a_r9_row_limit : assert property (@(posedge clk) disable iff (!rst_ni)
    (in_valid && !in_sor) |-> (row_cnt_q < CNT_W'(MAX_DISKS)));

  // R2: a one-byte row leaves the XOR parity equal to the weighted ones
  a_r2_p_matches_single : assert property (@(posedge clk) disable iff (!rst_ni)
    (out_valid && $past(in_sor)) |-> (out_p == out_q));
endmodule

// File: tb/tpr_row_encoder_tb_top.sv
module tpr_row_encoder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_sor = 1'b0;
  logic       in_eor = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       out_valid;
  logic [7:0] out_p, out_q, out_r;

  always #2.5 clk = ~clk;

  tpr_row_encoder dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sor(in_sor),
    .in_eor(in_eor), .in_data(in_data), .out_valid(out_valid),
    .out_p(out_p), .out_q(out_q), .out_r(out_r)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [7:0] rb [0:254];

  // {len, d3, d2, d1, d0}; byte k is disk index k
  localparam logic [39:0] VEC [8] = '{
    {8'd1, 8'h00, 8'h00, 8'h00, 8'h5A},
    {8'd2, 8'h00, 8'h00, 8'h01, 8'h00},
    {8'd2, 8'h00, 8'h00, 8'h80, 8'h80},
    {8'd3, 8'h00, 8'hFF, 8'h00, 8'h01},
    {8'd4, 8'h12, 8'h34, 8'h56, 8'h78},
    {8'd4, 8'hFF, 8'hFF, 8'hFF, 8'hFF},
    {8'd4, 8'h80, 8'h40, 8'h20, 8'h10},
    {8'd3, 8'h00, 8'hC3, 8'h3C, 8'hA5}
  };

  function automatic logic [7:0] m2(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1D : 8'h00);
  endfunction

  function automatic logic [7:0] mpow(input logic [7:0] a, input int n);
    logic [7:0] v = a;
    for (int j = 0; j < n; j++) v = m2(v);
    return v;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic finish_up;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      finish_up();
    end
  end

  task automatic send_row(input int len, input bit gaps, input bit no_wait);
    for (int k = len - 1; k >= 0; k--) begin
      if (!(no_wait && k == len - 1)) @(negedge clk);
      if (gaps) begin
        in_valid = 1'b0; in_sor = 1'b1; in_eor = 1'b1;
        in_data = 8'hA5 ^ 8'(k);
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_sor = (k == len - 1);
      in_eor = (k == 0);
      in_data = rb[k];
    end
  endtask

  task automatic check_row(input string tag, input int len);
    logic [7:0] ep = 8'h00, eq = 8'h00, er = 8'h00;
    for (int i = 0; i < len; i++) begin
      ep ^= rb[i];
      eq ^= mpow(rb[i], i);
      er ^= mpow(rb[i], 2 * i);
    end
    @(negedge clk);
    chk({tag, " R5 out_valid"}, {7'd0, out_valid}, 8'h01);
    chk({tag, " R2 P"}, out_p, ep);
    chk({tag, " R3 Q"}, out_q, eq);
    chk({tag, " R4 R"}, out_r, er);
    in_valid = 1'b0; in_sor = 1'b0; in_eor = 1'b0;
  endtask

  task automatic one_hot_row(input int len, input int idx);
    for (int i = 0; i < 255; i++) rb[i] = 8'h00;
    rb[idx] = 8'h01;
    send_row(len, 1'b0, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < 255; i++) rb[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", {7'd0, out_valid}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 out_valid", {7'd0, out_valid}, 8'h00);
    chk("R1 out_p", out_p, 8'h00);
    chk("R1 out_q", out_q, 8'h00);
    chk("R1 out_r", out_r, 8'h00);

    // model self-check of field constants
    chk("R9 model 2^8", mpow(8'h01, 8), 8'h1D);
    chk("R9 model 2^255", mpow(8'h01, 255), 8'h01);

    // table-driven rows
    for (int v = 0; v < 8; v++) begin
      int len = int'(VEC[v][39:32]);
      for (int i = 0; i < 4; i++) rb[i] = VEC[v][8*i +: 8];
      send_row(len, 1'b0, 1'b0);
      check_row($sformatf("vec%0d", v), len);
      @(negedge clk);
      chk("R5 pulse ends", {7'd0, out_valid}, 8'h00);
    end

    // R8: one-byte row
    rb[0] = 8'hC7;
    send_row(1, 1'b0, 1'b0);
    @(negedge clk);
    chk("R8 P", out_p, 8'hC7);
    chk("R8 Q", out_q, 8'hC7);
    chk("R8 R", out_r, 8'hC7);
    in_valid = 1'b0; in_sor = 1'b0; in_eor = 1'b0;

    // R7: idle cycles with junk and markers inside a row
    rb[0] = 8'h11; rb[1] = 8'h22; rb[2] = 8'h33; rb[3] = 8'h44; rb[4] = 8'h99;
    send_row(5, 1'b1, 1'b0);
    check_row("R7 gaps", 5);

    // R6: back-to-back rows, second starts on the pulse cycle
    rb[0] = 8'hDE; rb[1] = 8'hAD; rb[2] = 8'hBE;
    send_row(3, 1'b0, 1'b0);
    check_row("R6 first", 3);
    rb[0] = 8'h01; rb[1] = 8'h02; rb[2] = 8'h03;
    send_row(3, 1'b0, 1'b1);
    check_row("R6 second", 3);

    // R9: known powers through the datapath
    one_hot_row(9, 8);
    @(negedge clk);
    chk("R9 Q idx8", out_q, 8'h1D);
    in_valid = 1'b0; in_sor = 1'b0; in_eor = 1'b0;
    one_hot_row(13, 12);
    @(negedge clk);
    chk("R9 Q idx12", out_q, 8'hCD);
    in_valid = 1'b0; in_sor = 1'b0; in_eor = 1'b0;
    one_hot_row(255, 254);
    @(negedge clk);
    chk("R9 Q idx254", out_q, 8'h8E);
    chk("R9 R idx254", out_r, 8'h47);
    in_valid = 1'b0; in_sor = 1'b0; in_eor = 1'b0;

    // R9: full-width row with mixed data
    for (int i = 0; i < 255; i++) rb[i] = 8'(i * 37 + 5);
    send_row(255, 1'b0, 1'b0);
    check_row("R9 full", 255);
    @(negedge clk);
    chk("R5 idle after full", {7'd0, out_valid}, 8'h00);

    finish_up();
  end
endmodule